// File: doc/BRIEF.md
# Two-way page descriptor cache

This block keeps recently used page descriptors close to the address translation logic of a memory management unit. Storage is split into sections; each section holds a fixed number of rows, and every row carries two entries, called left and right. An entry keeps a tag, a valid bit, a page descriptor word and a 2-bit permission code. A single replacement bit per row, held alongside the left entry, steers where the next fill lands.

A lookup is combinational: it presents a virtual address and an access type and gets back hit, the descriptor and a permission verdict. Fills, flushes of one address, of one section or of everything, and OR-updates of modified/referenced bits into a cached descriptor are commands that act on the clock edge. The walk through translation tables in memory lies outside this block. The walker fills the cache after a miss.

Virtual address layout with default parameters: bits [31:30] are the section number, bits [29:14] the tag, bits [13:11] the row index within the section, bits [10:0] the page offset (ignored by the cache).

Top module: `pdw_cache`

## Requirements
- R1: While rst_ni is low and after its release, every entry is invalid and every replacement bit is 0, so every lookup returns hit_o=0.
- R2: The row used is section*8+index (section = va[31:30], index = va[13:11]); an entry hits only if it is valid and its tag equals va[29:14]; va[10:0] has no effect.
- R3: A lookup tests left before right; on a miss hit_o, fault_o and perm_ok_o are 0 and pd_o is 0.
- R4: A fill into a row whose left entry is invalid writes the left entry and clears the replacement bit; if left is valid and right is invalid it writes the right entry and sets the bit.
- R5: A fill into a row with both entries valid writes the right entry and sets the bit when the bit is 0, and writes the left entry and clears the bit when it is 1.
- R6: A single-address flush invalidates only the first entry of the row whose tag matches, left tested before right.
- R7: A section flush invalidates both entries in every row of the named section and leaves other sections intact.
- R8: A full flush invalidates every entry in every section.
- R9: Permission codes: 0 denies all; 1 allows only access types 4 and 5 (instruction fetches); 2 allows types 0 (address fetch), 1 (operand fetch), 3 (move-translated read), 4 and 5; 3 allows every type, including 2 (write) and 6..15.
- R10: A hit whose permission check fails gives fault_o=1, perm_ok_o=0 and pd_o=0; a permitted hit gives perm_ok_o=1, fault_o=0 and the stored descriptor.
- R11: An update ORs upd_mask_i into the descriptor of the first valid matching entry, left before right; with no match nothing changes.
- R12: With several commands in one cycle only one acts, chosen in the order full flush, section flush, single flush, fill, update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_acc_i | input | 4 | Lookup access type |
| hit_o | output | 1 | A valid entry matches the lookup |
| pd_o | output | 24 | Descriptor of the hit, 0 on miss or fault |
| perm_ok_o | output | 1 | Hit and access permitted |
| fault_o | output | 1 | Hit but access denied |
| fill_i | input | 1 | Fill command |
| fill_va_i | input | 32 | Address of the fill |
| fill_pd_i | input | 24 | Descriptor to store |
| fill_perm_i | input | 2 | Permission code to store |
| flush_va_i | input | 1 | Single-address flush command |
| flush_addr_i | input | 32 | Address to flush |
| flush_sec_i | input | 1 | Section flush command |
| flush_sec_id_i | input | 2 | Section to flush |
| flush_all_i | input | 1 | Full flush command |
| upd_i | input | 1 | Bit-update command |
| upd_va_i | input | 32 | Address whose descriptor is updated |
| upd_mask_i | input | 24 | Bits ORed into the descriptor |

## Verification
The two functions that collide are a fill and any of the commands above it in priority (a flush of the whole cache, of a section or of one address), plus a fill and a bit update to the same address. The bench raises these together in one cycle, with the fill aimed at a row where an earlier fill has left a known entry. It then judges the outcome with lookups only: the losing fill must miss, the winning flush must have removed its target, and a losing update must leave the freshly filled descriptor without the mask bits.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  typedef enum logic [2:0] {
    OP_IDLE, OP_FLUSH_ALL, OP_FLUSH_SEC, OP_FLUSH_VA, OP_FILL, OP_UPDATE
  } op_e;

  typedef enum logic [1:0] {
    PERM_NONE = 2'd0, PERM_EXEC = 2'd1, PERM_READ_EXEC = 2'd2, PERM_ALL = 2'd3
  } perm_e;

  localparam int ACC_W = 4;
  localparam logic [ACC_W-1:0] ACC_ADDR_FETCH  = 4'd0;
  localparam logic [ACC_W-1:0] ACC_OPND_FETCH  = 4'd1;
  localparam logic [ACC_W-1:0] ACC_MOVE_RD     = 4'd3;
  localparam logic [ACC_W-1:0] ACC_INSTR_FETCH = 4'd4;
  localparam logic [ACC_W-1:0] ACC_INSTR_JUMP  = 4'd5;
endpackage

// File: rtl/pdw_addr_split.sv
module pdw_addr_split #(
  parameter int SEC_W = 2,
  parameter int TAG_W = 16,
  parameter int IDX_W = 3,
  localparam int HI_W  = SEC_W + TAG_W + IDX_W,
  localparam int ROW_W = SEC_W + IDX_W
) (
  input  logic [HI_W-1:0]  va_hi_i,
  output logic [ROW_W-1:0] row_o,
  output logic [TAG_W-1:0] tag_o
);
  localparam int ROWS = 1 << IDX_W;

  logic [SEC_W-1:0] sec;
  logic [IDX_W-1:0] idx;

  assign sec   = va_hi_i[HI_W-1 -: SEC_W];
  assign tag_o = va_hi_i[IDX_W +: TAG_W];
  assign idx   = va_hi_i[IDX_W-1:0];
  // row = section * rows_per_section + index
  assign row_o = ROW_W'(sec) * ROW_W'(ROWS) + ROW_W'(idx);
endmodule

// File: rtl/pdw_perm_check.sv
module pdw_perm_check
  import pdw_pkg::*;
(
  input  logic [1:0]       perm_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic             ok_o
);
  logic is_fetch;
  logic is_read;

  always_comb begin
    is_fetch = (acc_i == ACC_INSTR_FETCH) || (acc_i == ACC_INSTR_JUMP);
    is_read  = is_fetch || (acc_i == ACC_ADDR_FETCH) ||
               (acc_i == ACC_OPND_FETCH) || (acc_i == ACC_MOVE_RD);
    case (perm_e'(perm_i))
      PERM_NONE:      ok_o = 1'b0;
      PERM_EXEC:      ok_o = is_fetch;
      PERM_READ_EXEC: ok_o = is_read;
      default:        ok_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/pdw_row.sv
module pdw_row
  import pdw_pkg::*;
#(
  parameter int TAG_W = 16,
  parameter int PD_W  = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  op_e              op_i,
  input  logic             row_sel_i,
  input  logic             sec_sel_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [PD_W-1:0]  pd_i,
  input  logic [1:0]       perm_i,
  input  logic [PD_W-1:0]  mask_i,
  output logic             l_good_o,
  output logic [TAG_W-1:0] l_tag_o,
  output logic [PD_W-1:0]  l_pd_o,
  output logic [1:0]       l_perm_o,
  output logic             r_good_o,
  output logic [TAG_W-1:0] r_tag_o,
  output logic [PD_W-1:0]  r_pd_o,
  output logic [1:0]       r_perm_o
);
  logic             l_good_q, r_good_q, used_q;
  logic [TAG_W-1:0] l_tag_q, r_tag_q;
  logic [PD_W-1:0]  l_pd_q, r_pd_q;
  logic [1:0]       l_perm_q, r_perm_q;

  logic l_match, r_match;
  logic fill_l, fill_r, upd_l, upd_r, clr_l, clr_r;

  assign l_match = l_good_q && (l_tag_q == tag_i);
  assign r_match = r_good_q && (r_tag_q == tag_i);

  always_comb begin
    fill_l = 1'b0; fill_r = 1'b0;
    upd_l  = 1'b0; upd_r  = 1'b0;
    clr_l  = 1'b0; clr_r  = 1'b0;
    case (op_i)
      OP_FLUSH_ALL: begin clr_l = 1'b1; clr_r = 1'b1; end
      OP_FLUSH_SEC: begin clr_l = sec_sel_i; clr_r = sec_sel_i; end
      OP_FLUSH_VA: if (row_sel_i) begin
        clr_l = l_match;
        clr_r = !l_match && r_match;
      end
      OP_FILL: if (row_sel_i) begin
        // left when empty, or when both full and the replacement bit points left
        fill_l = !l_good_q || (r_good_q && used_q);
        fill_r = !fill_l;
      end
      OP_UPDATE: if (row_sel_i) begin
        upd_l = l_match;
        upd_r = !l_match && r_match;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_good_q <= 1'b0;
      r_good_q <= 1'b0;
      used_q   <= 1'b0;
    end else begin
      if (clr_l)       l_good_q <= 1'b0;
      else if (fill_l) l_good_q <= 1'b1;
      if (clr_r)       r_good_q <= 1'b0;
      else if (fill_r) r_good_q <= 1'b1;
      if (fill_l)      used_q <= 1'b0;
      else if (fill_r) used_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_l) begin
      l_tag_q  <= tag_i;
      l_pd_q   <= pd_i;
      l_perm_q <= perm_i;
    end else if (upd_l) begin
      l_pd_q <= l_pd_q | mask_i;
    end
    if (fill_r) begin
      r_tag_q  <= tag_i;
      r_pd_q   <= pd_i;
      r_perm_q <= perm_i;
    end else if (upd_r) begin
      r_pd_q <= r_pd_q | mask_i;
    end
  end

  assign l_good_o = l_good_q;
  assign l_tag_o  = l_tag_q;
  assign l_pd_o   = l_pd_q;
  assign l_perm_o = l_perm_q;
  assign r_good_o = r_good_q;
  assign r_tag_o  = r_tag_q;
  assign r_pd_o   = r_pd_q;
  assign r_perm_o = r_perm_q;
endmodule

// File: rtl/pdw_cache.sv
module pdw_cache
  import pdw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int SEC_W = 2,
  parameter int IDX_W = 3,
  parameter int OFF_W = 11,
  parameter int PD_W  = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VA_W-1:0]  lk_va_i,
  input  logic [ACC_W-1:0] lk_acc_i,
  output logic             hit_o,
  output logic [PD_W-1:0]  pd_o,
  output logic             perm_ok_o,
  output logic             fault_o,
  input  logic             fill_i,
  input  logic [VA_W-1:0]  fill_va_i,
  input  logic [PD_W-1:0]  fill_pd_i,
  input  logic [1:0]       fill_perm_i,
  input  logic             flush_va_i,
  input  logic [VA_W-1:0]  flush_addr_i,
  input  logic             flush_sec_i,
  input  logic [SEC_W-1:0] flush_sec_id_i,
  input  logic             flush_all_i,
  input  logic             upd_i,
  input  logic [VA_W-1:0]  upd_va_i,
  input  logic [PD_W-1:0]  upd_mask_i
);
  localparam int TAG_W = VA_W - SEC_W - IDX_W - OFF_W;
  localparam int ROW_W = SEC_W + IDX_W;
  localparam int ROWS  = 1 << IDX_W;
  localparam int NROW  = 1 << ROW_W;

  // command arbitration
  op_e             op;
  logic [VA_W-1:0] cmd_va;

  always_comb begin
    op     = OP_IDLE;
    cmd_va = upd_va_i;
    if (flush_all_i)      op = OP_FLUSH_ALL;
    else if (flush_sec_i) op = OP_FLUSH_SEC;
    else if (flush_va_i) begin
      op     = OP_FLUSH_VA;
      cmd_va = flush_addr_i;
    end else if (fill_i) begin
      op     = OP_FILL;
      cmd_va = fill_va_i;
    end else if (upd_i) op = OP_UPDATE;
  end

  logic [OFF_W-1:0] unused_off;
  assign unused_off = cmd_va[OFF_W-1:0] ^ lk_va_i[OFF_W-1:0];

  logic [ROW_W-1:0] cmd_row, lk_row;
  logic [TAG_W-1:0] cmd_tag, lk_tag;

  pdw_addr_split #(.SEC_W(SEC_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_cmd_split (
    .va_hi_i (cmd_va[VA_W-1:OFF_W]),
    .row_o   (cmd_row),
    .tag_o   (cmd_tag)
  );

  pdw_addr_split #(.SEC_W(SEC_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_lk_split (
    .va_hi_i (lk_va_i[VA_W-1:OFF_W]),
    .row_o   (lk_row),
    .tag_o   (lk_tag)
  );

  // storage
  logic             l_good [NROW];
  logic [TAG_W-1:0] l_tag  [NROW];
  logic [PD_W-1:0]  l_pd   [NROW];
  logic [1:0]       l_perm [NROW];
  logic             r_good [NROW];
  logic [TAG_W-1:0] r_tag  [NROW];
  logic [PD_W-1:0]  r_pd   [NROW];
  logic [1:0]       r_perm [NROW];

  for (genvar r = 0; r < NROW; r++) begin : g_row
    localparam logic [SEC_W-1:0] RSEC = SEC_W'(r / ROWS);
    logic row_sel, sec_sel;
    assign row_sel = (cmd_row == ROW_W'(r));
    assign sec_sel = (flush_sec_id_i == RSEC);

    pdw_row #(.TAG_W(TAG_W), .PD_W(PD_W)) u_row (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .op_i      (op),
      .row_sel_i (row_sel),
      .sec_sel_i (sec_sel),
      .tag_i     (cmd_tag),
      .pd_i      (fill_pd_i),
      .perm_i    (fill_perm_i),
      .mask_i    (upd_mask_i),
      .l_good_o  (l_good[r]),
      .l_tag_o   (l_tag[r]),
      .l_pd_o    (l_pd[r]),
      .l_perm_o  (l_perm[r]),
      .r_good_o  (r_good[r]),
      .r_tag_o   (r_tag[r]),
      .r_pd_o    (r_pd[r]),
      .r_perm_o  (r_perm[r])
    );
  end

  // lookup, left entry first
  logic            l_hit, r_hit, acc_ok;
  logic [PD_W-1:0] sel_pd;
  logic [1:0]      sel_perm;

  assign l_hit    = l_good[lk_row] && (l_tag[lk_row] == lk_tag);
  assign r_hit    = r_good[lk_row] && (r_tag[lk_row] == lk_tag);
  assign sel_pd   = l_hit ? l_pd[lk_row]   : r_pd[lk_row];
  assign sel_perm = l_hit ? l_perm[lk_row] : r_perm[lk_row];

  pdw_perm_check u_perm (
    .perm_i (sel_perm),
    .acc_i  (lk_acc_i),
    .ok_o   (acc_ok)
  );

  assign hit_o     = l_hit || r_hit;
  assign perm_ok_o = hit_o && acc_ok;
  assign fault_o   = hit_o && !acc_ok;
  assign pd_o      = perm_ok_o ? sel_pd : '0;
endmodule

// File: rtl/pdw_checker.sv
module pdw_checker #(
  parameter int VA_W  = 32,
  parameter int SEC_W = 2,
  parameter int PD_W  = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [VA_W-1:0]  lk_va_i,
  input logic             hit_o,
  input logic [PD_W-1:0]  pd_o,
  input logic             perm_ok_o,
  input logic             fault_o,
  input logic             fill_i,
  input logic [VA_W-1:0]  fill_va_i,
  input logic [1:0]       fill_perm_i,
  input logic             flush_va_i,
  input logic             flush_sec_i,
  input logic [SEC_W-1:0] flush_sec_id_i,
  input logic             flush_all_i
);
  logic fill_wins;
  assign fill_wins = fill_i && !flush_all_i && !flush_sec_i && !flush_va_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) a_r1_empty_in_reset: assert (!hit_o && !fault_o);
  end

  a_r3_miss_is_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (!fault_o && !perm_ok_o && pd_o == '0));

  a_r4_fill_then_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fill_wins) && lk_va_i == $past(fill_va_i)) |-> hit_o);

  a_r9_perm_none_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fill_wins && fill_perm_i == 2'd0) && lk_va_i == $past(fill_va_i))
      |-> (fault_o && !perm_ok_o));

  a_r7_section_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flush_sec_i && !flush_all_i) &&
     lk_va_i[VA_W-1 -: SEC_W] == $past(flush_sec_id_i)) |-> !hit_o);

  a_r8_all_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_all_i) |-> !hit_o);
endmodule

bind pdw_cache pdw_checker #(.VA_W(VA_W), .SEC_W(SEC_W), .PD_W(PD_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lk_va_i        (lk_va_i),
  .hit_o          (hit_o),
  .pd_o           (pd_o),
  .perm_ok_o      (perm_ok_o),
  .fault_o        (fault_o),
  .fill_i         (fill_i),
  .fill_va_i      (fill_va_i),
  .fill_perm_i    (fill_perm_i),
  .flush_va_i     (flush_va_i),
  .flush_sec_i    (flush_sec_i),
  .flush_sec_id_i (flush_sec_id_i),
  .flush_all_i    (flush_all_i)
);

// File: tb/pdw_cache_tb_top.sv
`timescale 1ns/1ps
module pdw_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lk_va_i = '0;
  logic [3:0]  lk_acc_i = '0;
  logic        hit_o, perm_ok_o, fault_o;
  logic [23:0] pd_o;
  logic        fill_i = 1'b0;
  logic [31:0] fill_va_i = '0;
  logic [23:0] fill_pd_i = '0;
  logic [1:0]  fill_perm_i = '0;
  logic        flush_va_i = 1'b0;
  logic [31:0] flush_addr_i = '0;
  logic        flush_sec_i = 1'b0;
  logic [1:0]  flush_sec_id_i = '0;
  logic        flush_all_i = 1'b0;
  logic        upd_i = 1'b0;
  logic [31:0] upd_va_i = '0;
  logic [23:0] upd_mask_i = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pdw_cache dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .lk_va_i(lk_va_i), .lk_acc_i(lk_acc_i),
    .hit_o(hit_o), .pd_o(pd_o), .perm_ok_o(perm_ok_o), .fault_o(fault_o),
    .fill_i(fill_i), .fill_va_i(fill_va_i), .fill_pd_i(fill_pd_i), .fill_perm_i(fill_perm_i),
    .flush_va_i(flush_va_i), .flush_addr_i(flush_addr_i),
    .flush_sec_i(flush_sec_i), .flush_sec_id_i(flush_sec_id_i), .flush_all_i(flush_all_i),
    .upd_i(upd_i), .upd_va_i(upd_va_i), .upd_mask_i(upd_mask_i)
  );

  // kinds: 0 lookup, 1 fill (aux = perm), 2 update (data = mask), 3 single flush
  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] va;
    logic [23:0] data;
    logic [3:0]  aux;
    logic        e_hit;
    logic        e_fault;
    logic [4:0]  req;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 32'h40005000, 24'h000000, 4'd1, 1'b0, 1'b0, 5'd1},  // R1 empty
    '{2'd1, 32'h40005000, 24'h000111, 4'd3, 1'b0, 1'b0, 5'd4},  // R4 left
    '{2'd0, 32'h40005000, 24'h000111, 4'd2, 1'b1, 1'b0, 5'd4},
    '{2'd0, 32'h400057FF, 24'h000111, 4'd2, 1'b1, 1'b0, 5'd2},  // R2 offset ignored
    '{2'd0, 32'h80005000, 24'h000000, 4'd2, 1'b0, 1'b0, 5'd2},  // R2 other section
    '{2'd0, 32'h40005800, 24'h000000, 4'd2, 1'b0, 1'b0, 5'd2},  // R2 other row
    '{2'd1, 32'h40009000, 24'h000222, 4'd3, 1'b0, 1'b0, 5'd4},  // R4 right
    '{2'd0, 32'h40009000, 24'h000222, 4'd1, 1'b1, 1'b0, 5'd4},
    '{2'd0, 32'h40005000, 24'h000111, 4'd1, 1'b1, 1'b0, 5'd4},
    '{2'd1, 32'h4000D000, 24'h000333, 4'd3, 1'b0, 1'b0, 5'd5},  // R5 bit=1 -> left
    '{2'd0, 32'h40005000, 24'h000000, 4'd1, 1'b0, 1'b0, 5'd5},
    '{2'd0, 32'h40009000, 24'h000222, 4'd1, 1'b1, 1'b0, 5'd5},
    '{2'd0, 32'h4000D000, 24'h000333, 4'd1, 1'b1, 1'b0, 5'd5},
    '{2'd1, 32'h40011000, 24'h000444, 4'd3, 1'b0, 1'b0, 5'd5},  // R5 bit=0 -> right
    '{2'd0, 32'h40009000, 24'h000000, 4'd1, 1'b0, 1'b0, 5'd5},
    '{2'd0, 32'h4000D000, 24'h000333, 4'd1, 1'b1, 1'b0, 5'd5},
    '{2'd0, 32'h40011000, 24'h000444, 4'd1, 1'b1, 1'b0, 5'd5},
    '{2'd2, 32'h4000D000, 24'h800000, 4'd0, 1'b0, 1'b0, 5'd11}, // R11 OR mask
    '{2'd0, 32'h4000D000, 24'h800333, 4'd1, 1'b1, 1'b0, 5'd11},
    '{2'd2, 32'h40005000, 24'h400000, 4'd0, 1'b0, 1'b0, 5'd11}, // R11 no match
    '{2'd0, 32'h4000D000, 24'h800333, 4'd1, 1'b1, 1'b0, 5'd11},
    '{2'd0, 32'h40011000, 24'h000444, 4'd1, 1'b1, 1'b0, 5'd11},
    '{2'd3, 32'h4000D000, 24'h000000, 4'd0, 1'b0, 1'b0, 5'd6},  // R6 flush one
    '{2'd0, 32'h4000D000, 24'h000000, 4'd1, 1'b0, 1'b0, 5'd6},
    '{2'd0, 32'h40011000, 24'h000444, 4'd1, 1'b1, 1'b0, 5'd6},
    '{2'd1, 32'h00014000, 24'h000055, 4'd1, 1'b0, 1'b0, 5'd9},  // R9 code 1
    '{2'd0, 32'h00014000, 24'h000055, 4'd4, 1'b1, 1'b0, 5'd9},
    '{2'd0, 32'h00014000, 24'h000055, 4'd5, 1'b1, 1'b0, 5'd9},
    '{2'd0, 32'h00014000, 24'h000000, 4'd0, 1'b1, 1'b1, 5'd10}, // R10 fault
    '{2'd0, 32'h00014000, 24'h000000, 4'd2, 1'b1, 1'b1, 5'd10},
    '{2'd1, 32'h00018000, 24'h000066, 4'd2, 1'b0, 1'b0, 5'd9},  // R9 code 2
    '{2'd0, 32'h00018000, 24'h000066, 4'd0, 1'b1, 1'b0, 5'd9},
    '{2'd0, 32'h00018000, 24'h000066, 4'd1, 1'b1, 1'b0, 5'd9},
    '{2'd0, 32'h00018000, 24'h000066, 4'd3, 1'b1, 1'b0, 5'd9},
    '{2'd0, 32'h00018000, 24'h000066, 4'd4, 1'b1, 1'b0, 5'd9},
    '{2'd0, 32'h00018000, 24'h000000, 4'd2, 1'b1, 1'b1, 5'd10},
    '{2'd1, 32'h0001C800, 24'h000077, 4'd0, 1'b0, 1'b0, 5'd9},  // R9 code 0
    '{2'd0, 32'h0001C800, 24'h000000, 4'd4, 1'b1, 1'b1, 5'd9},
    '{2'd0, 32'h0001C800, 24'h000000, 4'd1, 1'b1, 1'b1, 5'd9},
    '{2'd1, 32'h00020800, 24'h000088, 4'd3, 1'b0, 1'b0, 5'd9},  // R9 code 3
    '{2'd0, 32'h00020800, 24'h000088, 4'd2, 1'b1, 1'b0, 5'd9},
    '{2'd0, 32'h00020800, 24'h000088, 4'd6, 1'b1, 1'b0, 5'd9}
  };

  task automatic drive(input logic fa, input logic fs, input logic [1:0] sid,
                       input logic fv, input logic [31:0] fva,
                       input logic fl, input logic [31:0] lva, input logic [23:0] lpd,
                       input logic [1:0] lperm,
                       input logic up, input logic [31:0] uva, input logic [23:0] um);
    @(negedge clk);
    flush_all_i = fa; flush_sec_i = fs; flush_sec_id_i = sid;
    flush_va_i = fv; flush_addr_i = fva;
    fill_i = fl; fill_va_i = lva; fill_pd_i = lpd; fill_perm_i = lperm;
    upd_i = up; upd_va_i = uva; upd_mask_i = um;
    @(negedge clk);
    flush_all_i = 1'b0; flush_sec_i = 1'b0; flush_va_i = 1'b0;
    fill_i = 1'b0; upd_i = 1'b0;
  endtask

  task automatic do_fill(input logic [31:0] va, input logic [23:0] pd, input logic [1:0] pm);
    drive(0, 0, 2'd0, 0, 32'h0, 1, va, pd, pm, 0, 32'h0, 24'h0);
  endtask

  task automatic look(input logic [31:0] va, input logic [3:0] acc, input logic eh,
                      input logic ef, input logic [23:0] epd, input string req);
    logic e_ok;
    e_ok = eh && !ef;
    lk_va_i = va; lk_acc_i = acc;
    #1;
    n_chk++;
    if (hit_o !== eh || fault_o !== ef || perm_ok_o !== e_ok || pd_o !== epd) begin
      n_fail++;
      $display("FAIL %s va=%08h acc=%0d: hit=%0b fault=%0b ok=%0b pd=%06h, expected hit=%0b fault=%0b ok=%0b pd=%06h",
               req, va, acc, hit_o, fault_o, perm_ok_o, pd_o, eh, ef, e_ok, epd);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    // R1: empty during reset
    repeat (3) @(negedge clk);
    look(32'h40005000, 4'd1, 0, 0, 24'h0, "R1");
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].kind)
        2'd0: look(TBL[i].va, TBL[i].aux, TBL[i].e_hit, TBL[i].e_fault, TBL[i].data,
                   $sformatf("R%0d", TBL[i].req));
        2'd1: do_fill(TBL[i].va, TBL[i].data, TBL[i].aux[1:0]);
        2'd2: drive(0, 0, 2'd0, 0, 32'h0, 0, 32'h0, 24'h0, 2'd0, 1, TBL[i].va, TBL[i].data);
        default: drive(0, 0, 2'd0, 1, TBL[i].va, 0, 32'h0, 24'h0, 2'd0, 0, 32'h0, 24'h0);
      endcase
    end

    // R1: asynchronous reset mid-run empties the cache
    @(negedge clk);
    rst_ni = 1'b0;
    look(32'h40011000, 4'd1, 0, 0, 24'h0, "R1");
    look(32'h00018000, 4'd1, 0, 0, 24'h0, "R1");
    @(negedge clk);
    rst_ni = 1'b1;
    look(32'h00020800, 4'd2, 0, 0, 24'h0, "R1");

    // R3 / R6: same tag twice lands left then right
    do_fill(32'h60002000, 24'h0000A1, 2'd3);
    do_fill(32'h60002000, 24'h0000B2, 2'd3);
    look(32'h60002000, 4'd1, 1, 0, 24'h0000A1, "R3");
    drive(0, 0, 2'd0, 1, 32'h60002000, 0, 32'h0, 24'h0, 2'd0, 0, 32'h0, 24'h0);
    look(32'h60002000, 4'd1, 1, 0, 24'h0000B2, "R6");
    drive(0, 0, 2'd0, 1, 32'h60002000, 0, 32'h0, 24'h0, 2'd0, 0, 32'h0, 24'h0);
    look(32'h60002000, 4'd1, 0, 0, 24'h0, "R6");

    // R7: section flush
    do_fill(32'h40000000, 24'h000C01, 2'd3);
    do_fill(32'h40003800, 24'h000C02, 2'd3);
    do_fill(32'h80000000, 24'h000C03, 2'd3);
    drive(0, 1, 2'd1, 0, 32'h0, 0, 32'h0, 24'h0, 2'd0, 0, 32'h0, 24'h0);
    look(32'h40000000, 4'd1, 0, 0, 24'h0, "R7");
    look(32'h40003800, 4'd1, 0, 0, 24'h0, "R7");
    look(32'h80000000, 4'd1, 1, 0, 24'h000C03, "R7");

    // R8: full flush
    do_fill(32'hC0004000, 24'h000D01, 2'd3);
    drive(1, 0, 2'd0, 0, 32'h0, 0, 32'h0, 24'h0, 2'd0, 0, 32'h0, 24'h0);
    look(32'h80000000, 4'd1, 0, 0, 24'h0, "R8");
    look(32'hC0004000, 4'd1, 0, 0, 24'h0, "R8");

    // R12: full flush beats fill
    do_fill(32'h00004000, 24'h000E01, 2'd3);
    drive(1, 0, 2'd0, 0, 32'h0, 1, 32'h00008000, 24'h000E02, 2'd3, 0, 32'h0, 24'h0);
    look(32'h00008000, 4'd1, 0, 0, 24'h0, "R12");
    look(32'h00004000, 4'd1, 0, 0, 24'h0, "R12");
    // R12: section flush beats single flush and fill
    do_fill(32'h00004000, 24'h000E01, 2'd3);
    drive(0, 1, 2'd3, 1, 32'h00004000, 1, 32'h00008000, 24'h000E02, 2'd3, 0, 32'h0, 24'h0);
    look(32'h00004000, 4'd1, 1, 0, 24'h000E01, "R12");
    look(32'h00008000, 4'd1, 0, 0, 24'h0, "R12");
    // R12: single flush beats fill
    drive(0, 0, 2'd0, 1, 32'h00004000, 1, 32'h00008000, 24'h000E02, 2'd3, 0, 32'h0, 24'h0);
    look(32'h00004000, 4'd1, 0, 0, 24'h0, "R12");
    look(32'h00008000, 4'd1, 0, 0, 24'h0, "R12");
    // R12: fill beats update
    drive(0, 0, 2'd0, 0, 32'h0, 1, 32'h0000C000, 24'h0000AA, 2'd3, 1, 32'h0000C000, 24'h100000);
    look(32'h0000C000, 4'd1, 1, 0, 24'h0000AA, "R12");
    drive(0, 0, 2'd0, 0, 32'h0, 0, 32'h0, 24'h0, 2'd0, 1, 32'h0000C000, 24'h100000);
    look(32'h0000C000, 4'd1, 1, 0, 24'h1000AA, "R11");

    finish_run();
  end
endmodule